// File: doc/BRIEF.md
# Translation Buffer with Access Protection

This block caches recent virtual-to-physical page translations for 32-bit virtual addresses and grants or refuses each access against the permission bits stored with the translation. A requester presents a virtual address, the kind of access (instruction fetch, data load or data store) and whether the core is in user mode. In the same cycle the block answers with exactly one of three outcomes. The first is a granted physical address. The second is a miss, which tells the requester to start a page table walk. The third is a protection fault.

The walker hands a finished translation back through the refill port. A refill first takes an empty slot. When every slot is in use, it displaces one chosen in rotating order. A flush input drops every cached translation so that later lookups see fresh page tables. The physical address is 34 bits wide. It is the 22-bit physical page number from the matching slot, followed by the 12 low bits of the virtual address unchanged.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no slot holds a translation, so any request reports a miss.
- R2: On a hit whose permissions allow the access, rsp_ok is high in the same cycle as req_valid, and rsp_paddr is the stored 22-bit page number concatenated with req_vaddr[11:0].
- R3: On a miss, only rsp_miss is high and rsp_paddr is zero.
- R4: req_kind encodes 0 = fetch, 1 = load, 2 = store and 3 = reserved. A fetch needs X, a load needs R and a store needs W. The reserved kind is always refused. In fill_perm, bit 0 is R, bit 1 is W, bit 2 is X, bit 3 is U and bit 4 is G.
- R5: A user-mode request (req_user = 1) to a page whose U bit is clear is refused. A supervisor request is not affected by U.
- R6: A refused hit raises only rsp_fault, and rsp_paddr stays zero.
- R7: When req_valid is high, exactly one of rsp_ok, rsp_miss and rsp_fault is high. When req_valid is low, all three are low.
- R8: A refill goes into the lowest-numbered empty slot while any slot is empty, and the rotating pointer does not move.
- R9: With all slots full, a refill replaces the slot at the rotating pointer (0 after reset), and the pointer then advances by one and wraps.
- R10: A refill whose page number is already cached overwrites that slot, evicts nothing, and leaves the pointer unchanged.
- R11: flush empties every slot at the next clock edge. A refill presented in the same cycle as flush is discarded.
- R12: A refill becomes visible from the cycle after it is presented. A lookup in the same cycle sees the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_ok | output | 1 | Hit with access granted |
| rsp_miss | output | 1 | No cached translation, walk needed |
| rsp_fault | output | 1 | Hit but access refused |
| rsp_paddr | output | 34 | Physical address, zero unless rsp_ok |
| fill_valid | input | 1 | Refill translation present |
| fill_vpn | input | 20 | Virtual page number of refill |
| fill_ppn | input | 22 | Physical page number of refill |
| fill_perm | input | 5 | Permission bits {G,U,X,W,R} |
| flush | input | 1 | Invalidate all translations |

## Verification
The assertions assume that rst is held for at least one clock edge before any check can fire. They also assume that refill and flush are driven only between edges, with no glitch. The refill property further assumes that a request naming a just-refilled page is not also being flushed. The bench keeps to these conditions by driving every input on the falling edge and holding reset for several cycles. It never issues flush during the cycle right after a refill whose page it then looks up, except in the one directed case where the flush is expected to win.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       user,
  input  perm_t      perm,
  output logic       allow
);
  logic kind_ok;

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH: kind_ok = perm.x;
      ACC_LOAD:  kind_ok = perm.r;
      ACC_STORE: kind_ok = perm.w;
      default:   kind_ok = 1'b0;
    endcase
    allow = kind_ok && (!user || perm.u);
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 22,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  perm_t            wr_perm,
  input  logic [VPN_W-1:0] look_vpn,
  output logic [N_ENT-1:0] look_hit,
  output logic [N_ENT-1:0] fill_hit,
  output logic [N_ENT-1:0] valid_vec,
  output logic [PPN_W-1:0] hit_ppn,
  output perm_t            hit_perm
);
  logic [N_ENT-1:0] vld_q;
  logic [VPN_W-1:0] vpn_q  [N_ENT];
  logic [PPN_W-1:0] ppn_q  [N_ENT];
  perm_t            perm_q [N_ENT];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[wr_idx]  <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  generate
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
      assign look_hit[gi] = vld_q[gi] && (vpn_q[gi] == look_vpn);
      assign fill_hit[gi] = vld_q[gi] && (vpn_q[gi] == wr_vpn);
    end
  endgenerate

  assign valid_vec = vld_q;

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < N_ENT; i++) begin
      hit_ppn  = hit_ppn  | (ppn_q[i] & {PPN_W{look_hit[i]}});
      hit_perm = hit_perm | (perm_q[i] & {$bits(perm_t){look_hit[i]}});
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_go,
  input  logic [N_ENT-1:0] valid_vec,
  input  logic [N_ENT-1:0] dup_vec,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             have_dup;
  logic             have_free;

  always_comb begin
    dup_idx   = '0;
    free_idx  = '0;
    have_dup  = 1'b0;
    have_free = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (dup_vec[i]) begin
        dup_idx  = IDX_W'(i);
        have_dup = 1'b1;
      end
      if (!valid_vec[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
    if (have_dup)       victim = dup_idx;
    else if (have_free) victim = free_idx;
    else                victim = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_go && !have_dup && !have_free) begin
      rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 34,
  parameter int OFF_W = 12,
  parameter int N_ENT = 8,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_ok,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [4:0]       fill_perm,
  input  logic             flush
);
  logic [N_ENT-1:0] look_hit;
  logic [N_ENT-1:0] fill_hit;
  logic [N_ENT-1:0] valid_vec;
  logic [PPN_W-1:0] hit_ppn;
  perm_t            hit_perm;
  logic [IDX_W-1:0] victim;
  logic             allow;
  logic             any_hit;
  logic             fill_go;

  assign fill_go = fill_valid && !flush;

  tlb_entry_store #(.N_ENT(N_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(fill_go), .wr_idx(victim), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .wr_perm(perm_t'(fill_perm)),
    .look_vpn(req_vaddr[VA_W-1:OFF_W]),
    .look_hit(look_hit), .fill_hit(fill_hit), .valid_vec(valid_vec),
    .hit_ppn(hit_ppn), .hit_perm(hit_perm)
  );

  tlb_victim_sel #(.N_ENT(N_ENT)) u_victim (
    .clk(clk), .rst(rst), .fill_go(fill_go),
    .valid_vec(valid_vec), .dup_vec(fill_hit), .victim(victim)
  );

  tlb_perm_chk u_perm (
    .kind(req_kind), .user(req_user), .perm(hit_perm), .allow(allow)
  );

  assign any_hit   = |look_hit;
  assign rsp_ok    = req_valid && any_hit && allow;
  assign rsp_fault = req_valid && any_hit && !allow;
  assign rsp_miss  = req_valid && !any_hit;
  assign rsp_paddr = rsp_ok ? {hit_ppn, req_vaddr[OFF_W-1:0]} : '0;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 34,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_ok,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            fill_valid,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic            flush
);
  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $countones({rsp_ok, rsp_miss, rsp_fault}) == 1);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !(rsp_ok || rsp_miss || rsp_fault));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ok |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_fault) |-> rsp_paddr == '0);

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && !$past(rst) && req_valid) |-> rsp_miss);

  // R12
  fill_seen_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid && !flush) && !$past(rst) && req_valid &&
     req_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> !rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .rsp_ok(rsp_ok), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
  .flush(flush)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        rsp_ok, rsp_miss, rsp_fault;
  logic [33:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [21:0] fill_ppn = '0;
  logic [4:0]  fill_perm = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .rsp_ok(rsp_ok),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .flush(flush)
  );

  // outcome codes: 0 granted, 1 miss, 2 fault
  typedef struct packed {
    logic [1:0]  kind;
    logic        user;
    logic [31:0] va;
    logic [1:0]  code;
    logic [33:0] pa;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 32'h0001_05A4, 2'd0, {22'h3ABCD, 12'h5A4}},  // R2 user load A
    '{2'd2, 1'b1, 32'h0001_0FFF, 2'd0, {22'h3ABCD, 12'hFFF}},  // R4 user store A
    '{2'd0, 1'b1, 32'h0001_0000, 2'd2, 34'd0},                 // R4 fetch A no X
    '{2'd0, 1'b0, 32'h0002_0123, 2'd0, {22'h00123, 12'h123}},  // R5 supervisor fetch B
    '{2'd0, 1'b1, 32'h0002_0123, 2'd2, 34'd0},                 // R5 user on B, U=0
    '{2'd1, 1'b0, 32'h0002_0040, 2'd2, 34'd0},                 // R6 load B no R
    '{2'd1, 1'b1, 32'h0003_0777, 2'd0, {22'h2FFFF, 12'h777}},  // R2 user load C
    '{2'd2, 1'b1, 32'h0003_0777, 2'd2, 34'd0},                 // R4 store C no W
    '{2'd1, 1'b0, 32'h0004_0000, 2'd1, 34'd0},                 // R3 miss
    '{2'd3, 1'b0, 32'h0001_0010, 2'd2, 34'd0},                 // R4 reserved kind
    '{2'd1, 1'b0, 32'h0001_0020, 2'd0, {22'h3ABCD, 12'h020}}   // R5 supervisor on U page
  };

  task automatic look(input logic [1:0] kind, input logic user,
                      input logic [31:0] va, input logic [1:0] code,
                      input logic [33:0] pa, input string tag);
    logic [1:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_user = user; req_vaddr = va;
    #2;
    checks++;
    got = rsp_ok ? 2'd0 : rsp_miss ? 2'd1 : rsp_fault ? 2'd2 : 2'd3;
    if (got != code || rsp_paddr != pa ||
        (32'(rsp_ok) + 32'(rsp_miss) + 32'(rsp_fault)) != 1) begin
      fails++;
      $display("FAIL %s va=%h got code=%0d pa=%h expected code=%0d pa=%h",
               tag, va, got, rsp_paddr, code, pa);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [21:0] ppn,
                      input logic [4:0] perm);
    @(negedge clk);
    req_valid = 1'b0;
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    req_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got hang, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look(2'd1, 1'b0, 32'h0001_0000, 2'd1, 34'd0, "R1 reset miss");
    @(negedge clk);
    req_valid = 1'b0; #2;
    checks++;
    if (rsp_ok || rsp_miss || rsp_fault) begin
      fails++;
      $display("FAIL R7 idle outputs got %b expected 000", {rsp_ok, rsp_miss, rsp_fault});
    end

    // perm bits {G,U,X,W,R}
    fill(20'h00010, 22'h3ABCD, 5'b01011);
    fill(20'h00020, 22'h00123, 5'b00100);
    fill(20'h00030, 22'h2FFFF, 5'b01101);

    for (int i = 0; i < NV; i++)
      look(VECS[i].kind, VECS[i].user, VECS[i].va, VECS[i].code, VECS[i].pa,
           $sformatf("vector %0d", i));

    // R12: lookup in the refill cycle sees old contents
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00050; fill_ppn = 22'h00555; fill_perm = 5'b00111;
    req_valid = 1'b1; req_kind = 2'd1; req_user = 1'b0; req_vaddr = 32'h0005_0008;
    #2;
    checks++;
    if (!rsp_miss) begin
      fails++;
      $display("FAIL R12 same-cycle got miss=%b expected 1", rsp_miss);
    end
    @(negedge clk);
    fill_valid = 1'b0; #2;
    checks++;
    if (!rsp_ok || rsp_paddr != {22'h00555, 12'h008}) begin
      fails++;
      $display("FAIL R12 next-cycle got pa=%h expected %h", rsp_paddr, {22'h00555, 12'h008});
    end

    // R11: flush empties
    do_flush();
    look(2'd1, 1'b0, 32'h0001_0000, 2'd1, 34'd0, "R11 flush A");
    look(2'd1, 1'b0, 32'h0005_0000, 2'd1, 34'd0, "R11 flush refill");

    // R8: fill all slots from empty, all hit
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 22'h01000 + 22'(i), 5'b00001);
    for (int i = 0; i < 8; i++)
      look(2'd1, 1'b0, {20'h00100 + 20'(i), 12'h004}, 2'd0,
           {22'h01000 + 22'(i), 12'h004}, "R8 fill order");

    // R9: ninth refill evicts slot 0, tenth evicts slot 1
    fill(20'h00108, 22'h01008, 5'b00001);
    look(2'd1, 1'b0, 32'h0010_0000, 2'd1, 34'd0, "R9 evict first");
    look(2'd1, 1'b0, 32'h0010_1000, 2'd0, {22'h01001, 12'h000}, "R9 keep second");
    fill(20'h00109, 22'h01009, 5'b00001);
    look(2'd1, 1'b0, 32'h0010_1000, 2'd1, 34'd0, "R9 evict second");
    look(2'd1, 1'b0, 32'h0010_8000, 2'd0, {22'h01008, 12'h000}, "R9 new entry");

    // R10: refill of a cached page overwrites in place
    fill(20'h00104, 22'h0ABCD, 5'b00001);
    look(2'd1, 1'b0, 32'h0010_4ABC, 2'd0, {22'h0ABCD, 12'hABC}, "R10 updated");
    for (int i = 2; i < 10; i++)
      if (i != 4)
        look(2'd1, 1'b0, {20'h00100 + 20'(i), 12'h000}, 2'd0,
             {22'h01000 + 22'(i), 12'h000}, "R10 no eviction");
    // pointer stayed at 2: next refill evicts page 0x102
    fill(20'h0010A, 22'h0100A, 5'b00001);
    look(2'd1, 1'b0, 32'h0010_2000, 2'd1, 34'd0, "R10 pointer unchanged");
    look(2'd1, 1'b0, 32'h0010_3000, 2'd0, {22'h01003, 12'h000}, "R10 neighbour kept");

    // R11: flush beats a simultaneous refill
    @(negedge clk);
    req_valid = 1'b0;
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00077; fill_ppn = 22'h00077; fill_perm = 5'b00001;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look(2'd1, 1'b0, 32'h0007_7000, 2'd1, 34'd0, "R11 refill dropped");
    look(2'd1, 1'b0, 32'h0010_3000, 2'd1, 34'd0, "R11 all cleared");

    @(negedge clk);
    req_valid = 1'b0;
    finish_run();
  end
endmodule